// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This peripheral sits on a simple register bus and exposes three 8-bit parallel ports, called A, B and C. Port C is split into an upper and a lower nibble, and each nibble has its own direction. A chip select and a 2-bit address pick one of four registers: the three port data registers and a write-only command register. Writes land on a rising clock edge. Reads are combinational from the address.

The command register accepts two kinds of word, told apart by bit 7. A configuration word (bit 7 = 1) sets the direction of each pin group and clears every output latch. A single-bit command (bit 7 = 0) sets or clears one port C bit and leaves the other bits alone. Only plain, unhandshaken input and output is carried out. A configuration word that asks for a strobed or bidirectional mode is still accepted, but it raises a sticky flag.

Each pin group drives its latch onto its pins only while it is set to output. A group set to input reads back the sampled pin value instead of the latch.

Top module: `par_port_unit`

## Requirements
- R1: After reset, every pin group is an input, so all output enables are 0. The A, B and C latches hold 0xFF, and `modeUnsupported` is 0.
- R2: A write with `cs`=1 at address 0, 1 or 2 stores the byte in the latch of port A, B or C. The stored value appears on that port's `*Out` bus after the clock edge.
- R3: A configuration word (address 3, bit 7 = 1) sets the port directions. Bit 4 controls port A, bit 1 port B, bit 3 the upper nibble of port C and bit 0 the lower nibble of port C. A value of 1 means input (enables 0) and 0 means output (enables all 1).
- R4: A configuration word clears the A, B and C latches to 0x00.
- R5: A single-bit command (address 3, bit 7 = 0) writes bit 0 into the port C bit indexed by bits 3:1. All other port C bits are unchanged.
- R6: A read of address 3 returns 0xFF.
- R7: A read of port A or B returns the latch when the port is set to output and the pin input when it is set to input.
- R8: A read of port C builds each nibble separately: from the latch if that nibble is set to output, and from the pins if it is set to input.
- R9: A write to a port set to input still updates its latch, which is visible on its `*Out` bus while its enables stay 0.
- R10: `modeUnsupported` goes to 1 after a configuration word with bit 2 = 1 or bits 6:5 non-zero. It stays 1 through any later writes until reset.
- R11: A write with `cs`=0 changes no latch, direction or flag. A read with `cs`=0 or `rdEn`=0 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register select: 0=A, 1=B, 2=C, 3=command |
| wrEn | input | 1 | Write strobe, sampled on the clock edge |
| rdEn | input | 1 | Read enable for the combinational read data |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| portAIn | input | 8 | Sampled port A pins |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A output enables |
| portBIn | input | 8 | Sampled port B pins |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B output enables |
| portCIn | input | 8 | Sampled port C pins |
| portCOut | output | 8 | Port C output latch |
| portCOe | output | 8 | Port C output enables, upper and lower nibble separately |
| modeUnsupported | output | 1 | Sticky flag: a handshaking mode was requested |

## Verification
The assertions assume the bus control inputs carry known values whenever reset is released. They also assume `wrEn` lasts one cycle per access, so each strobe matches exactly one register update.

The stimulus changes inputs only on falling clock edges and pulses `wrEn` for a single cycle. Pin inputs change only while no write is pending. Random command words use bit 7 to pick between configuration words and single-bit commands. Directed cases cover split port C directions, writes to ports set to input, and deselected writes.

// File: rtl/par_port_pkg.sv
package par_port_pkg;
  parameter int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              cfgWr;
    logic              bitWr;
    logic [PORT_W-1:0] wData;
  } strobe_t;

  typedef struct packed {
    logic inA;
    logic inB;
    logic inCHi;
    logic inCLo;
  } dir_t;
endpackage

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
  import par_port_pkg::*;
#(
  parameter logic [PORT_W-1:0] RST_CMD = 8'h9B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrData,
  output strobe_t           strb,
  output dir_t              dir,
  output logic              modeUnsupported
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic selWr;
  logic askHandshake;

  always_comb begin
    selWr        = cs & wrEn;
    strb.wrA     = selWr && (addr == 2'd0);
    strb.wrB     = selWr && (addr == 2'd1);
    strb.wrC     = selWr && (addr == 2'd2);
    strb.cfgWr   = selWr && (addr == CMD_ADDR) && wrData[7];
    strb.bitWr   = selWr && (addr == CMD_ADDR) && !wrData[7];
    strb.wData   = wrData;
    askHandshake = wrData[2] | (wrData[6:5] != 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dir <= '{inA: RST_CMD[4], inB: RST_CMD[1], inCHi: RST_CMD[3], inCLo: RST_CMD[0]};
      modeUnsupported <= 1'b0;
    end else if (strb.cfgWr) begin
      dir <= '{inA: wrData[4], inB: wrData[1], inCHi: wrData[3], inCLo: wrData[0]};
      if (askHandshake) modeUnsupported <= 1'b1;
    end
  end

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWr |=> (dir.inA == $past(wrData[4]) && dir.inB == $past(wrData[1]) &&
                    dir.inCHi == $past(wrData[3]) && dir.inCLo == $past(wrData[0])));
  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeUnsupported |=> modeUnsupported);
  // R11
  no_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs |-> !(strb.wrA | strb.wrB | strb.wrC | strb.cfgWr | strb.bitWr));
endmodule

// File: rtl/par_port_dp.sv
module par_port_dp
  import par_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  dir_t              dir,
  input  logic              rdSel,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portCOe
);
  logic [PORT_W-1:0] latA, latB, latC;
  logic [PORT_W-1:0] viewA, viewB, viewC;
  logic [IDX_W-1:0]  bitIdx;

  assign bitIdx = strb.wData[IDX_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latA <= '1;
      latB <= '1;
      latC <= '1;
    end else if (strb.cfgWr) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (strb.wrA) latA <= strb.wData;
      if (strb.wrB) latB <= strb.wData;
      if (strb.wrC) latC <= strb.wData;
      else if (strb.bitWr) latC[bitIdx] <= strb.wData[0];
    end
  end

  always_comb begin
    viewA = dir.inA ? portAIn : latA;
    viewB = dir.inB ? portBIn : latB;
    viewC[PORT_W-1:HALF_W] = dir.inCHi ? portCIn[PORT_W-1:HALF_W] : latC[PORT_W-1:HALF_W];
    viewC[HALF_W-1:0]      = dir.inCLo ? portCIn[HALF_W-1:0] : latC[HALF_W-1:0];
    rdData = '0;
    if (rdSel) begin
      unique case (addr)
        2'd0:    rdData = viewA;
        2'd1:    rdData = viewB;
        2'd2:    rdData = viewC;
        default: rdData = '1;
      endcase
    end
  end

  assign portAOut = latA;
  assign portBOut = latB;
  assign portCOut = latC;
  assign portAOe  = {PORT_W{~dir.inA}};
  assign portBOe  = {PORT_W{~dir.inB}};
  assign portCOe  = {{HALF_W{~dir.inCHi}}, {HALF_W{~dir.inCLo}}};

  // R4
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWr |=> (latA == '0 && latB == '0 && latC == '0));
  // R5
  bit_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitWr |=> (latC[$past(bitIdx)] == $past(strb.wData[0])));
  // R6
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel && addr == 2'd3) |-> (rdData == '1));
  // R2
  a_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrA && !strb.cfgWr) |=> (latA == $past(strb.wData)));
endmodule

// File: rtl/par_port_unit.sv
module par_port_unit
  import par_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] rdData,
  input  logic [PORT_W-1:0] portAIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portCOe,
  output logic              modeUnsupported
);
  strobe_t strb;
  dir_t    dir;
  logic    rdSel;

  assign rdSel = cs & rdEn;

  par_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .strb(strb), .dir(dir), .modeUnsupported(modeUnsupported)
  );

  par_port_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dir(dir), .rdSel(rdSel), .addr(addr),
    .portAIn(portAIn), .portBIn(portBIn), .portCIn(portCIn), .rdData(rdData),
    .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut), .portBOe(portBOe),
    .portCOut(portCOut), .portCOe(portCOe)
  );
endmodule

// File: tb/sim_par_port_unit.sv
module sim_par_port_unit;
  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0, portAIn = '0, portBIn = '0, portCIn = '0;
  logic [7:0] rdData, portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;
  logic modeUnsupported;

  int nRun = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] mA, mB, mC;
  logic mInA, mInB, mInCHi, mInCLo, mUnsup;

  always #10 clk = ~clk;

  par_port_unit u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [1:0] a, logic [7:0] pa, logic [7:0] pb, logic [7:0] pc);
    case (a)
      2'd0: return mInA ? pa : mA;
      2'd1: return mInB ? pb : mB;
      2'd2: return {mInCHi ? pc[7:4] : mC[7:4], mInCLo ? pc[3:0] : mC[3:0]};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic modelReset();
    mA = 8'hFF; mB = 8'hFF; mC = 8'hFF;
    {mInA, mInB, mInCHi, mInCLo} = 4'b1111; mUnsup = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    modelReset();
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d, logic sel);
    @(negedge clk);
    cs = sel; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    cs = 1'b0; wrEn = 1'b0;
    if (sel) begin
      case (a)
        2'd0: mA = d;
        2'd1: mB = d;
        2'd2: mC = d;
        default:
          if (d[7]) begin
            mA = 0; mB = 0; mC = 0;
            mInA = d[4]; mInB = d[1]; mInCHi = d[3]; mInCLo = d[0];
            if (d[2] || d[6:5] != 0) mUnsup = 1'b1;
          end else mC[d[3:1]] = d[0];
      endcase
    end
  endtask

  // Compare all observable state; reads happen inside one low clock phase.
  task automatic checkAll(string tag);
    #1;
    check({tag, " R1/R2/R9 A latch"}, portAOut, mA);
    check({tag, " R2/R9 B latch"}, portBOut, mB);
    check({tag, " R2/R5 C latch"}, portCOut, mC);
    check({tag, " R3 A enables"}, portAOe, {8{~mInA}});
    check({tag, " R3 B enables"}, portBOe, {8{~mInB}});
    check({tag, " R3 C enables"}, portCOe, {{4{~mInCHi}}, {4{~mInCLo}}});
    check({tag, " R10 flag"}, {7'd0, modeUnsupported}, {7'd0, mUnsup});
    for (int a = 0; a < 4; a++) begin
      portAIn = 8'($urandom); portBIn = 8'($urandom); portCIn = 8'($urandom);
      cs = 1'b1; rdEn = 1'b1; addr = 2'(a);
      #1;
      check({tag, " R6/R7/R8 read"}, rdData, expRead(2'(a), portAIn, portBIn, portCIn));
    end
    rdEn = 1'b0;
    #1;
    check({tag, " R11 idle read"}, rdData, 8'h00);
    cs = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    doReset();
    checkAll("R1 reset");
    busWrite(2'd3, 8'h80, 1'b1); checkAll("R4 all-out");
    busWrite(2'd0, 8'h5A, 1'b1); checkAll("R2 A write");
    busWrite(2'd3, 8'h0B, 1'b1); checkAll("R5 set C5");
    busWrite(2'd3, 8'h0A, 1'b1); checkAll("R5 clear C5");
    busWrite(2'd1, 8'hC3, 1'b0); checkAll("R11 deselected");
    busWrite(2'd3, 8'h9B, 1'b0); checkAll("R11 deselected cmd");
    busWrite(2'd3, 8'h88, 1'b1); busWrite(2'd2, 8'hA5, 1'b1); checkAll("R8 split hi-in");
    busWrite(2'd3, 8'h81, 1'b1); busWrite(2'd2, 8'h3C, 1'b1); checkAll("R8 split lo-in");
    busWrite(2'd3, 8'h90, 1'b1); busWrite(2'd0, 8'h33, 1'b1); checkAll("R9 input write");
    busWrite(2'd3, 8'hA0, 1'b1); checkAll("R10 mode1 A");
    busWrite(2'd3, 8'h80, 1'b1); checkAll("R10 stays");
    doReset(); checkAll("R1 second reset");
    busWrite(2'd3, 8'h84, 1'b1); checkAll("R10 mode1 B");
    doReset();
    busWrite(2'd3, 8'hC0, 1'b1); checkAll("R10 mode2");
    doReset();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      logic [1:0] a;
      d = 8'($urandom);
      a = 2'($urandom);
      if (a == 2'd3 && d[7] && ($urandom % 4 != 0)) d[6:5] = 2'b00;
      if (a == 2'd3 && d[7] && ($urandom % 4 != 0)) d[2] = 1'b0;
      busWrite(a, d, ($urandom % 8) != 0);
      checkAll("random");
      if (i % 100 == 99) begin doReset(); checkAll("R1 random reset"); end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule